// File: doc/BRIEF.md
# CPU Run-State and Interrupt Entry Sequencer

This block decides, once per CPU step, whether a 16-bit coprocessor core keeps executing, sits halted, or idles while it waits for an interrupt. It also decides whether an interrupt entry starts in the current step, and which vector address that entry fetches. The instruction decoder sends it one-cycle pulses for the halt (STP) and wait-for-interrupt (WAI) instructions. The interrupt sources are a level IRQ line and an NMI line. A per-step strobe tells the block when a CPU step, either an idle cycle or a bus cycle, takes place. Nothing moves while the strobe is low.

Interrupt acceptance works from flags latched on the previous step, so every entry lags its cause by one step. NMI is edge-triggered and outranks IRQ. Halt is final until reset, yet the step counter keeps running in that state. Leaving the wait state costs an idle step in the wait state itself and then one more idle step in the running state before any entry can start. The stack push, the vector fetch and the register file belong to the surrounding core. This block only produces the `int_take` strobe and the vector address.

Top module: `cpu_runstate_seq`

## Requirements
- R1: During and after reset, `run_state` is Running (encoding 0), `cycle_cnt` is 0, and `int_take` and `idle_req` are low. Reset also clears the pending NMI and the previous-step flags.
- R2: `cycle_cnt` advances by one on every step (`cyc_en` high) in every state and holds otherwise. With `cyc_en` low, `int_take` and `idle_req` are low, and no IRQ or NMI input is latched.
- R3: An IRQ level seen in one step causes an interrupt entry in the next Running step, with native vector 0xFFEE. When IRQ is low in the step before, no entry occurs.
- R4: A low-to-high transition of `nmi_in` sets a pending NMI. The entry (native vector 0xFFEA) comes one step later and clears the pending flag. If the line is held high, no second entry follows.
- R5: When NMI and IRQ are both latched, NMI is entered first. An IRQ that is still latched is entered in the following step.
- R6: With `emu_mode` high the vectors are 0xFFFA for NMI and 0xFFFE for IRQ. Bit 4 of the vector therefore equals `emu_mode` whenever `int_take` is high.
- R7: A `stp_pulse` in an executing Running step moves `run_state` to Stopped (encoding 1). Only reset leaves Stopped. In Stopped, no entry and no idle request occur, and pulses and interrupt inputs are ignored.
- R8: A `wai_pulse` in an executing Running step moves `run_state` to Waiting (encoding 2). In Waiting, `idle_req` is high on every step. A step with IRQ high or NMI pending wakes the block. The next step is Running with `idle_req` high and no entry, and only the step after that can take an interrupt.
- R9: No entry occurs in a step that carries `stp_pulse` or `wai_pulse`. If both pulses arrive together, `stp_pulse` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | One CPU step (idle or bus cycle) happens this clock |
| irq_req | input | 1 | Level interrupt request |
| nmi_in | input | 1 | Non-maskable interrupt line, rising-edge sensitive |
| stp_pulse | input | 1 | Decoder executed the halt instruction |
| wai_pulse | input | 1 | Decoder executed the wait-for-interrupt instruction |
| emu_mode | input | 1 | Core is in emulation mode (selects legacy vectors) |
| run_state | output | 2 | 0 Running, 1 Stopped, 2 Waiting |
| idle_req | output | 1 | Insert an idle cycle in this step |
| int_take | output | 1 | Start interrupt entry in this step |
| int_vector | output | 16 | Vector address while `int_take` is high, else 0 |
| cycle_cnt | output | CNT_W | Free-running step counter |

## Verification
The hardest case to reach from the ports is waking from Waiting on a pending NMI. The NMI edge has to land while the block already waits, and the wake comes from the pending flag in a later step, not from the edge step. The entry then appears only after the extra Running idle step. The stimulus reaches this by issuing WAI, raising `nmi_in` in a Waiting step, and holding it high, so that a spurious second edge would show up as an extra entry. A similar sequence wakes on IRQ after a WAI pulse that also carried a latched IRQ, which shows the gating of the pulse step.

// File: rtl/cpu_runstate_seq.sv
module cpu_runstate_seq #(
  parameter int          CNT_W       = 32,
  parameter logic [15:0] VEC_NAT_NMI = 16'hFFEA,
  parameter logic [15:0] VEC_NAT_IRQ = 16'hFFEE,
  parameter logic [15:0] VEC_EMU_NMI = 16'hFFFA,
  parameter logic [15:0] VEC_EMU_IRQ = 16'hFFFE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             irq_req,
  input  logic             nmi_in,
  input  logic             stp_pulse,
  input  logic             wai_pulse,
  input  logic             emu_mode,
  output logic [1:0]       run_state,
  output logic             idle_req,
  output logic             int_take,
  output logic [15:0]      int_vector,
  output logic [CNT_W-1:0] cycle_cnt
);

  localparam logic [1:0] ST_RUN  = 2'd0;
  localparam logic [1:0] ST_STOP = 2'd1;
  localparam logic [1:0] ST_WAIT = 2'd2;

  logic [1:0]       st_q, st_d;
  logic             nmi_q, nmi_pend, prev_nmi, prev_irq, wake_idle;
  logic [CNT_W-1:0] cnt_q;

  wire executing  = cyc_en && (st_q == ST_RUN) && !wake_idle;
  wire halt_op    = stp_pulse || wai_pulse;
  wire take_nmi   = executing && !halt_op && prev_nmi;
  wire take_irq   = executing && !halt_op && !prev_nmi && prev_irq;
  wire nmi_rise   = nmi_in && !nmi_q;
  wire nmi_pend_d = (nmi_pend && !take_nmi) || nmi_rise;
  wire wake       = (st_q == ST_WAIT) && (irq_req || nmi_pend);

  always_comb begin
    st_d = st_q;
    if (executing && stp_pulse)      st_d = ST_STOP;
    else if (executing && wai_pulse) st_d = ST_WAIT;
    else if (cyc_en && wake)         st_d = ST_RUN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_RUN;
      nmi_q     <= 1'b0;
      nmi_pend  <= 1'b0;
      prev_nmi  <= 1'b0;
      prev_irq  <= 1'b0;
      wake_idle <= 1'b0;
      cnt_q     <= '0;
    end else if (cyc_en) begin
      st_q      <= st_d;
      nmi_q     <= nmi_in;
      nmi_pend  <= nmi_pend_d;
      prev_nmi  <= nmi_pend_d;
      prev_irq  <= irq_req;
      wake_idle <= wake;
      cnt_q     <= cnt_q + 1'b1;
    end
  end

  assign run_state  = st_q;
  assign cycle_cnt  = cnt_q;
  assign idle_req   = cyc_en && ((st_q == ST_WAIT) || wake_idle);
  assign int_take   = take_nmi || take_irq;
  assign int_vector = take_nmi ? (emu_mode ? VEC_EMU_NMI : VEC_NAT_NMI) :
                      take_irq ? (emu_mode ? VEC_EMU_IRQ : VEC_NAT_IRQ) : 16'h0000;

endmodule

module cpu_runstate_seq_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_en,
  input logic             irq_req,
  input logic             stp_pulse,
  input logic             wai_pulse,
  input logic             emu_mode,
  input logic [1:0]       run_state,
  input logic             idle_req,
  input logic             int_take,
  input logic [15:0]      int_vector,
  input logic [CNT_W-1:0] cycle_cnt
);

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en |=> cycle_cnt == CNT_W'($past(cycle_cnt) + 1'b1));

  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> $stable(cycle_cnt));

  assert_no_strobe_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |-> !int_take && !idle_req);

  assert_vec_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_take |-> int_vector[4] == emu_mode);

  assert_stop_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_state == 2'd1 |=> run_state == 2'd1);

  assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_state == 2'd1 |-> !int_take && !idle_req);

  assert_stp_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_state == 2'd0 && cyc_en && !idle_req && stp_pulse |=> run_state == 2'd1);

  assert_wait_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_state == 2'd2 && cyc_en |-> idle_req);

  assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_state == 2'd2 && cyc_en && irq_req |=> run_state == 2'd0 && !int_take);

  assert_take_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int_take |-> run_state == 2'd0 && !idle_req);

  assert_halt_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stp_pulse || wai_pulse) |-> !int_take);

endmodule

bind cpu_runstate_seq cpu_runstate_seq_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/cpu_runstate_seq_test.sv
module cpu_runstate_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_en = 1'b0, irq_req = 1'b0, nmi_in = 1'b0;
  logic stp_pulse = 1'b0, wai_pulse = 1'b0, emu_mode = 1'b0;
  logic [1:0]  run_state;
  logic        idle_req, int_take;
  logic [15:0] int_vector;
  logic [31:0] cycle_cnt;

  always #10 clk = ~clk;

  cpu_runstate_seq uut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .irq_req(irq_req), .nmi_in(nmi_in),
    .stp_pulse(stp_pulse), .wai_pulse(wai_pulse), .emu_mode(emu_mode),
    .run_state(run_state), .idle_req(idle_req), .int_take(int_take),
    .int_vector(int_vector), .cycle_cnt(cycle_cnt)
  );

  typedef struct {
    logic [1:0]  st;
    logic        idle;
    logic        take;
    logic [15:0] vec;
    logic [31:0] cnt;
    string       tag;
  } exp_t;

  exp_t  sb[$];
  int    n_run = 0, n_fail = 0;
  logic [31:0] mcnt = 0;

  task automatic step(input logic en, input logic irq, input logic nmi, input logic stp,
                      input logic wai, input logic emu, input logic [1:0] st,
                      input logic idle, input logic take, input logic [15:0] vec,
                      input string tag);
    exp_t e;
    @(negedge clk); #1;
    cyc_en = en; irq_req = irq; nmi_in = nmi;
    stp_pulse = stp; wai_pulse = wai; emu_mode = emu;
    e.st = st; e.idle = idle; e.take = take; e.vec = vec; e.cnt = mcnt; e.tag = tag;
    sb.push_back(e);
    if (en) mcnt = mcnt + 1;
  endtask

  always begin
    @(negedge clk); #8;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if (run_state !== e.st || idle_req !== e.idle || int_take !== e.take ||
          int_vector !== e.vec || cycle_cnt !== e.cnt) begin
        n_fail++;
        $display("FAIL %s: got st=%0d idle=%0b take=%0b vec=%h cnt=%0d, expected st=%0d idle=%0b take=%0b vec=%h cnt=%0d",
                 e.tag, run_state, idle_req, int_take, int_vector, cycle_cnt,
                 e.st, e.idle, e.take, e.vec, e.cnt);
      end
    end
  end

  task automatic check_reset(input string tag);
    @(negedge clk); #8;
    n_run++;
    if (run_state !== 2'd0 || cycle_cnt !== 32'd0 || int_take !== 1'b0 || idle_req !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: got st=%0d cnt=%0d take=%0b idle=%0b, expected st=0 cnt=0 take=0 idle=0",
               tag, run_state, cycle_cnt, int_take, idle_req);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 1'b0; cyc_en = 1'b1; irq_req = 1'b0; nmi_in = 1'b0;
    stp_pulse = 1'b0; wai_pulse = 1'b0; emu_mode = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1; cyc_en = 1'b0;
    mcnt = 0;
  endtask

  initial begin
    fork
      begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        check_reset("R1 after power-up reset");

        // R3 IRQ level latched, taken next step
        step(1,1,0,0,0,0, 2'd0,0,0,16'h0000, "R3 irq seen, no entry yet");
        step(1,0,0,0,0,0, 2'd0,0,1,16'hFFEE, "R3 irq entry native");
        step(1,0,0,0,0,0, 2'd0,0,0,16'h0000, "R3 no entry once irq low");

        // R4 NMI edge, held level not retaken
        step(1,0,1,0,0,0, 2'd0,0,0,16'h0000, "R4 nmi edge step");
        step(1,0,1,0,0,0, 2'd0,0,1,16'hFFEA, "R4 nmi entry native");
        step(1,0,1,0,0,0, 2'd0,0,0,16'h0000, "R4 held nmi not retaken");
        step(1,0,0,0,0,0, 2'd0,0,0,16'h0000, "R4 nmi released");

        // R5 priority
        step(1,1,1,0,0,0, 2'd0,0,0,16'h0000, "R5 both raised");
        step(1,1,1,0,0,0, 2'd0,0,1,16'hFFEA, "R5 nmi first");
        step(1,0,0,0,0,0, 2'd0,0,1,16'hFFEE, "R5 irq after nmi");
        step(1,0,0,0,0,0, 2'd0,0,0,16'h0000, "R5 quiet");

        // R6 emulation vectors
        step(1,1,0,0,0,1, 2'd0,0,0,16'h0000, "R6 irq seen emu");
        step(1,0,0,0,0,1, 2'd0,0,1,16'hFFFE, "R6 irq vector emu");
        step(1,0,1,0,0,1, 2'd0,0,0,16'h0000, "R6 nmi edge emu");
        step(1,0,0,0,0,1, 2'd0,0,1,16'hFFFA, "R6 nmi vector emu");
        step(1,0,0,0,0,0, 2'd0,0,0,16'h0000, "R6 quiet");

        // R2 no strobe: nothing latched, counter holds
        step(0,1,1,0,0,0, 2'd0,0,0,16'h0000, "R2 no strobe gated");
        step(0,1,0,0,0,0, 2'd0,0,0,16'h0000, "R2 no strobe counter held");
        step(1,0,0,0,0,0, 2'd0,0,0,16'h0000, "R2 nothing latched without strobe");

        // R9 + R7 halt
        step(1,1,0,0,0,0, 2'd0,0,0,16'h0000, "R9 irq latched");
        step(1,0,0,1,0,0, 2'd0,0,0,16'h0000, "R9 stp step suppresses entry");
        step(1,1,0,0,0,0, 2'd1,0,0,16'h0000, "R7 stopped");
        step(1,1,1,0,0,0, 2'd1,0,0,16'h0000, "R7 stopped ignores nmi");
        step(1,0,1,0,1,0, 2'd1,0,0,16'h0000, "R7 stopped ignores wai");
        step(1,0,0,0,0,0, 2'd1,0,0,16'h0000, "R7 stopped counter runs R2");
        step(0,0,0,0,0,0, 2'd1,0,0,16'h0000, "R7 stopped no strobe");

        do_reset();
        check_reset("R1 reset leaves stopped");

        // R8 wait, woken by IRQ
        step(1,0,0,0,1,0, 2'd0,0,0,16'h0000, "R8 wai issued");
        step(1,0,0,0,0,0, 2'd2,1,0,16'h0000, "R8 waiting idle");
        step(1,0,0,1,0,0, 2'd2,1,0,16'h0000, "R8 waiting ignores stp");
        step(1,1,0,0,0,0, 2'd2,1,0,16'h0000, "R8 wake step idle");
        step(1,1,0,0,0,0, 2'd0,1,0,16'h0000, "R8 extra running idle");
        step(1,0,0,0,0,0, 2'd0,0,1,16'hFFEE, "R8 irq entry after wake");
        step(1,0,0,0,0,0, 2'd0,0,0,16'h0000, "R8 quiet");

        // R8 wait, woken by pending NMI
        step(1,0,0,0,1,0, 2'd0,0,0,16'h0000, "R8 wai issued again");
        step(1,0,1,0,0,0, 2'd2,1,0,16'h0000, "R8 nmi edge while waiting");
        step(1,0,1,0,0,0, 2'd2,1,0,16'h0000, "R8 wake on pending nmi");
        step(1,0,1,0,0,0, 2'd0,1,0,16'h0000, "R8 extra idle before nmi");
        step(1,0,1,0,0,0, 2'd0,0,1,16'hFFEA, "R8 nmi entry after wake");
        step(1,0,0,0,0,0, 2'd0,0,0,16'h0000, "R8 no second nmi entry");

        // R9 wai step suppresses latched irq
        step(1,1,0,0,0,0, 2'd0,0,0,16'h0000, "R9 irq latched before wai");
        step(1,0,0,0,1,0, 2'd0,0,0,16'h0000, "R9 wai step suppresses entry");
        step(1,1,0,0,0,0, 2'd2,1,0,16'h0000, "R9 wake after wai");
        step(1,1,0,0,0,0, 2'd0,1,0,16'h0000, "R9 extra idle");
        step(1,0,0,0,0,0, 2'd0,0,1,16'hFFEE, "R9 irq entry after wake");

        // R9 both pulses: halt wins
        step(1,0,0,1,1,0, 2'd0,0,0,16'h0000, "R9 both pulses");
        step(1,1,0,0,0,0, 2'd1,0,0,16'h0000, "R9 stp wins over wai");

        @(negedge clk); @(negedge clk);
      end
      begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule